// File: doc/BRIEF.md
# Set-Associative Way Victim Selector

This block picks which way of an m-way set-associative cache gets evicted. For each set it keeps its own replacement state. It reads the set index of the current access, together with a hit strobe and the way that hit, and a fill strobe that marks a block being installed after a miss. From these it reports a victim way for the addressed set. Tag storage, data arrays and the sequencing of a miss all stay outside the block.

A build parameter chooses one of three policies, and all three use the same ports:

- **Random.** One counter is shared by every set and steps on each clock.
- **FIFO.** Each set has a round-robin pointer that moves only on a fill to that set.
- **Tree pseudo-LRU.** Each set keeps m−1 tree bits, updated on every hit and every fill.

A per-set valid mask takes priority over the chosen policy, so empty ways are always filled first. The victim is a combinational read of the state held for the addressed set. The state changes on the clock edge that carries a strobe.

Top module: `way_victim_sel`

## Requirements
- R1: While `rst` is high, every set reports victim way 0 under every policy. Reset clears all tree bits, round-robin pointers and the shared counter to zero.
- R2: Random policy: the victim equals one counter shared by all sets. The counter is 0 on the first rising edge at which `rst` is sampled low and adds one (mod m) on every following clock edge. Strobes and the set index do not affect it.
- R3: FIFO policy: the victim of a set is its pointer. The pointer adds one (mod m) on each clock edge where `fill_vld` is high for that set. Hits leave it unchanged.
- R4: FIFO policy: a fill into one set leaves the pointers of all other sets unchanged.
- R5: Pseudo-LRU policy: after a hit on way w in a set, that set does not report w as its victim on the next cycle.
- R6: Pseudo-LRU tree layout: nodes are numbered in heap order (root 1, children of n are 2n and 2n+1, leaf of way w is w+m). A node bit of 0 sends the victim walk to the lower-numbered child. A touch sets every node on the way's path to point away from the child the path came through. For m=4, touching ways 0,1,2,3 in that order makes way 0 the victim.
- R7: Pseudo-LRU policy: a fill updates the tree as though the way then reported as victim had been hit.
- R8: If `valid_mask` has any 0 bit (bit i = way i), the victim is the lowest-numbered way whose bit is 0, under any policy. A fill still advances FIFO state and updates tree state using this overridden way.
- R9: When `hit_vld` and `fill_vld` are both high in the same cycle, only the fill updates the state. The hit is ignored.
- R10: With m=2 under pseudo-LRU, the victim is always the way that was not touched most recently, which is exact LRU.
- R11: The victim follows `set_idx` within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_idx | input | $clog2(NUM_SETS) | Set addressed this cycle |
| hit_vld | input | 1 | Access hit in `hit_way` |
| hit_way | input | $clog2(NUM_WAYS) | Way that hit |
| fill_vld | input | 1 | Block installed into the reported victim way |
| valid_mask | input | NUM_WAYS | Occupied ways of the addressed set (1 = valid) |
| victim_way | output | $clog2(NUM_WAYS) | Way to evict for the addressed set |

## Verification
The victim is combinational, so after the bench drives a new set index or mask it is due in the same cycle. The bench checks it shortly after the inputs settle, before the next rising edge. A strobe takes effect at the following rising edge, so its effect on the victim appears from the next falling edge onward. The bench updates its reference models only after that rising edge.

The shared random counter changes on every edge. The bench tracks it with its own edge-driven model, which starts from the first edge that samples reset low.

Four instances (4-way pseudo-LRU, FIFO, random, and 2-way pseudo-LRU) see the same stimulus and are all compared on every cycle.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  typedef enum int {
    VSEL_RANDOM = 0,
    VSEL_FIFO   = 1,
    VSEL_PLRU   = 2
  } vsel_policy_e;
endpackage

// File: rtl/vsel_state_mem.sv
// Per-set replacement state: one synchronous write port, asynchronous read.
module vsel_state_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/vsel_plru_tree.sv
// Heap-ordered pseudo-LRU tree: node n stored at bit n-1, children 2n, 2n+1.
module vsel_plru_tree #(
  parameter int WAYS = 4,
  localparam int WW  = $clog2(WAYS),
  localparam int NB  = WAYS - 1
) (
  input  logic [NB-1:0] bits_i,
  input  logic [WW-1:0] touch_way_i,
  output logic [WW-1:0] lru_way_o,
  output logic [NB-1:0] bits_o
);
  // Walk from the root following each node bit (0 = lower child).
  always_comb begin
    int node;
    node = 1;
    for (int lvl = 0; lvl < WW; lvl++) begin
      node = 2 * node + (bits_i[node-1] ? 1 : 0);
    end
    lru_way_o = WW'(node - WAYS);
  end

  // Climb from the touched leaf, pointing each ancestor at the other child.
  always_comb begin
    int node;
    bits_o = bits_i;
    node   = int'(touch_way_i) + WAYS;
    for (int lvl = 0; lvl < WW; lvl++) begin
      bits_o[(node >> 1) - 1] = ((node % 2) == 0);
      node = node >> 1;
    end
  end
endmodule

// File: rtl/vsel_first_free.sv
// Lowest-numbered way whose valid bit is clear.
module vsel_first_free #(
  parameter int WAYS = 4,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] valid_i,
  output logic            any_free_o,
  output logic [WW-1:0]   free_way_o
);
  always_comb begin
    any_free_o = 1'b0;
    free_way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free_o = 1'b1;
        free_way_o = WW'(i);
      end
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
  parameter int                    NUM_SETS = 64,
  parameter int                    NUM_WAYS = 4,
  parameter vsel_pkg::vsel_policy_e POLICY  = vsel_pkg::VSEL_PLRU,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SET_W-1:0]    set_idx,
  input  logic                hit_vld,
  input  logic [WAY_W-1:0]    hit_way,
  input  logic                fill_vld,
  input  logic [NUM_WAYS-1:0] valid_mask,
  output logic [WAY_W-1:0]    victim_way
);
  localparam int TREE_W = NUM_WAYS - 1;

  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] policy_way;

  vsel_first_free #(.WAYS(NUM_WAYS)) u_free (
    .valid_i    (valid_mask),
    .any_free_o (any_free),
    .free_way_o (free_way)
  );

  // Empty ways win over any policy choice.
  assign victim_way = any_free ? free_way : policy_way;

  generate
    if (POLICY == vsel_pkg::VSEL_PLRU) begin : g_plru
      logic [TREE_W-1:0] tree_rd;
      logic [TREE_W-1:0] tree_wr;
      logic [WAY_W-1:0]  touch_way;
      logic              touch;

      // A fill outranks a simultaneous hit and marks the filled way MRU.
      assign touch     = hit_vld | fill_vld;
      assign touch_way = fill_vld ? victim_way : hit_way;

      vsel_state_mem #(.DEPTH(NUM_SETS), .WIDTH(TREE_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (touch),
        .addr  (set_idx),
        .wdata (tree_wr),
        .rdata (tree_rd)
      );

      vsel_plru_tree #(.WAYS(NUM_WAYS)) u_tree (
        .bits_i      (tree_rd),
        .touch_way_i (touch_way),
        .lru_way_o   (policy_way),
        .bits_o      (tree_wr)
      );
    end else if (POLICY == vsel_pkg::VSEL_FIFO) begin : g_fifo
      logic [WAY_W-1:0] ptr_rd;
      logic [WAY_W-1:0] ptr_wr;

      assign ptr_wr     = ptr_rd + WAY_W'(1);
      assign policy_way = ptr_rd;

      vsel_state_mem #(.DEPTH(NUM_SETS), .WIDTH(WAY_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (fill_vld),
        .addr  (set_idx),
        .wdata (ptr_wr),
        .rdata (ptr_rd)
      );
    end else begin : g_rand
      logic [WAY_W-1:0] tick_q;

      always_ff @(posedge clk) begin
        if (rst) tick_q <= '0;
        else     tick_q <= tick_q + WAY_W'(1);
      end

      assign policy_way = tick_q;
    end
  endgenerate
endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
  parameter int                    NUM_SETS = 64,
  parameter int                    NUM_WAYS = 4,
  parameter vsel_pkg::vsel_policy_e POLICY  = vsel_pkg::VSEL_PLRU,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rst,
  input logic [SET_W-1:0]    set_idx,
  input logic                hit_vld,
  input logic [WAY_W-1:0]    hit_way,
  input logic                fill_vld,
  input logic [NUM_WAYS-1:0] valid_mask,
  input logic [WAY_W-1:0]    victim_way
);
  logic                armed;
  logic [NUM_WAYS-1:0] below;
  logic                full;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assign below = NUM_WAYS'((1 << victim_way) - 1);
  assign full  = &valid_mask;

  // R8: override picks an invalid way with every lower way valid
  p_free_pick_r8: assert property (@(posedge clk) disable iff (rst)
    !full |-> (!valid_mask[victim_way] && ((valid_mask & below) == below)));

  generate
    if (POLICY == vsel_pkg::VSEL_RANDOM) begin : g_rand
      p_rand_step_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && full && $past(full)) |->
          victim_way == $past(victim_way) + WAY_W'(1));
    end else if (POLICY == vsel_pkg::VSEL_FIFO) begin : g_fifo
      p_fifo_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(fill_vld) && $stable(set_idx) && $stable(valid_mask))
          |-> $stable(victim_way));
      p_fifo_step_r3: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(fill_vld) && $stable(set_idx) && full && $past(full))
          |-> victim_way == $past(victim_way) + WAY_W'(1));
    end else begin : g_plru
      p_hit_not_mru_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(hit_vld) && !$past(fill_vld) && $stable(set_idx) && full)
          |-> victim_way != $past(hit_way));
      p_fill_not_mru_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(fill_vld) && $stable(set_idx) && full)
          |-> victim_way != $past(victim_way));
    end
  endgenerate
endmodule

bind way_victim_sel vsel_checker #(
  .NUM_SETS (NUM_SETS),
  .NUM_WAYS (NUM_WAYS),
  .POLICY   (POLICY)
) u_vsel_chk (
  .clk        (clk),
  .rst        (rst),
  .set_idx    (set_idx),
  .hit_vld    (hit_vld),
  .hit_way    (hit_way),
  .fill_vld   (fill_vld),
  .valid_mask (valid_mask),
  .victim_way (victim_way)
);

// File: tb/way_victim_sel_tb_top.sv
module way_victim_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] set_idx = '0;
  logic       hit_vld = 1'b0;
  logic [1:0] hit_way = '0;
  logic       fill_vld = 1'b0;
  logic [3:0] valid_mask = 4'hF;
  logic [1:0] vic_plru, vic_fifo, vic_rand;
  logic       vic_two;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  bit root_b [4];
  bit lo_b   [4];
  bit hi_b   [4];
  int fifo_c [4];
  int lru2   [4];
  int rcnt = 0;

  always #4 clk = ~clk;

  way_victim_sel #(.NUM_SETS(4), .NUM_WAYS(4), .POLICY(vsel_pkg::VSEL_PLRU)) dut_i (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way),
    .fill_vld(fill_vld), .valid_mask(valid_mask), .victim_way(vic_plru));
  way_victim_sel #(.NUM_SETS(4), .NUM_WAYS(4), .POLICY(vsel_pkg::VSEL_FIFO)) dut_fifo_i (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way),
    .fill_vld(fill_vld), .valid_mask(valid_mask), .victim_way(vic_fifo));
  way_victim_sel #(.NUM_SETS(4), .NUM_WAYS(4), .POLICY(vsel_pkg::VSEL_RANDOM)) dut_rand_i (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way),
    .fill_vld(fill_vld), .valid_mask(valid_mask), .victim_way(vic_rand));
  way_victim_sel #(.NUM_SETS(4), .NUM_WAYS(2), .POLICY(vsel_pkg::VSEL_PLRU)) dut_two_i (
    .clk(clk), .rst(rst), .set_idx(set_idx), .hit_vld(hit_vld), .hit_way(hit_way[0]),
    .fill_vld(fill_vld), .valid_mask(valid_mask[1:0]), .victim_way(vic_two));

  // R2 reference: shared counter, zero while reset is sampled high
  always @(posedge clk) begin
    if (rst) rcnt <= 0;
    else     rcnt <= (rcnt + 1) % 4;
  end

  function automatic int lowest_free(input logic [3:0] m, input int ways);
    for (int i = 0; i < ways; i++) if (!m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input string who, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, who, act, exp);
    end
  endtask

  task automatic step(input int s, input bit h, input int w, input bit f,
                      input logic [3:0] m, input string tag);
    int ep, ef, er, e2, fr4, fr2, tw, t2;
    @(negedge clk);
    set_idx = 2'(s); hit_vld = h; hit_way = 2'(w); fill_vld = f; valid_mask = m;
    #1;
    fr4 = lowest_free(m, 4);
    fr2 = lowest_free(m, 2);
    ep  = (root_b[s] == 0) ? (lo_b[s] ? 1 : 0) : (hi_b[s] ? 3 : 2);
    if (fr4 >= 0) ep = fr4;
    ef  = (fr4 >= 0) ? fr4 : fifo_c[s];
    er  = (fr4 >= 0) ? fr4 : rcnt;
    e2  = (fr2 >= 0) ? fr2 : lru2[s];
    chk(tag, "plru4", int'(vic_plru), ep);
    chk(tag, "fifo",  int'(vic_fifo), ef);
    chk(tag, "rand",  int'(vic_rand), er);
    chk(tag, "plru2", int'(vic_two),  e2);
    @(posedge clk);
    if (!rst) begin
      if (f || h) begin
        tw = f ? ep : w;          // R9: fill wins over a same-cycle hit
        if (tw < 2) begin root_b[s] = 1; lo_b[s] = (tw == 0); end
        else        begin root_b[s] = 0; hi_b[s] = (tw == 2); end
        t2 = f ? e2 : (w % 2);
        lru2[s] = 1 - t2;
      end
      if (f) fifo_c[s] = (fifo_c[s] + 1) % 4;
    end
    #1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      root_b[i] = 0; lo_b[i] = 0; hi_b[i] = 0; fifo_c[i] = 0; lru2[i] = 0;
    end
    // R1: held in reset, every set reports way 0
    for (int i = 0; i < 4; i++) step(i, 1'b0, 0, 1'b0, 4'hF, "R1");
    rst = 1'b0;
    // R11: set sweep with no strobes, victim follows index in-cycle
    for (int i = 0; i < 8; i++) step(i % 4, 1'b0, 0, 1'b0, 4'hF, "R11");
    // R6: touch 0,1,2,3 on set 0, then way 0 is the victim
    for (int w = 0; w < 4; w++) step(0, 1'b1, w, 1'b0, 4'hF, "R6");
    step(0, 1'b0, 0, 1'b0, 4'hF, "R6");
    // R5: hits across sets
    for (int i = 0; i < 150; i++)
      step($urandom % 4, 1'b1, $urandom % 4, 1'b0, 4'hF, "R5");
    // R3 / R7: fills and hits mixed
    for (int i = 0; i < 120; i++)
      step($urandom % 4, ($urandom % 2) == 1, $urandom % 4, 1'b1, 4'hF, "R7");
    for (int i = 0; i < 60; i++)
      step($urandom % 4, 1'b1, $urandom % 4, ($urandom % 3) == 0, 4'hF, "R3");
    // R4: fills only into set 2, then sweep the others
    for (int i = 0; i < 5; i++) step(2, 1'b0, 0, 1'b1, 4'hF, "R4");
    for (int i = 0; i < 4; i++) step(i, 1'b0, 0, 1'b0, 4'hF, "R4");
    // R9: hit and fill together
    for (int i = 0; i < 60; i++)
      step($urandom % 4, 1'b1, $urandom % 4, 1'b1, 4'hF, "R9");
    // R8: partial valid masks, all 16 patterns
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 6; k++)
        step($urandom % 4, ($urandom % 2) == 1, $urandom % 4, ($urandom % 2) == 1,
             4'(m), "R8");
    // R2: idle stretch, shared counter keeps stepping
    for (int i = 0; i < 20; i++) step(i % 4, 1'b0, 0, 1'b0, 4'hF, "R2");
    // R10: two-way exact LRU via alternating accesses
    for (int i = 0; i < 80; i++)
      step($urandom % 4, 1'b1, $urandom % 2, ($urandom % 4) == 0, 4'hF, "R10");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule